// File: doc/BRIEF.md
# Receive Descriptor Ring Index Tracker

This block sits on the device side of a receive path. Host software keeps a ring of receive buffer descriptors in its own memory. The ring holds a power of two entries, and each entry is one 32-bit word that names a 256-byte-aligned buffer. The host publishes empty buffers by moving a write index forward in steps of eight.

The tracker owns the read position. Whenever at least one published buffer is free, it asks memory for the descriptor word at its read position. It then offers the buffer address to the receive datapath and waits for a "buffer filled" pulse. Each accepted fill moves the read position forward by one. It also raises a status write-back request, which carries the index of the descriptor just filled and the 16-byte-aligned address of the host status buffer.

Equal read and write positions mean that no free buffer is left. For this reason, at most one entry fewer than the ring size can be outstanding. The block does not perform the memory transfers itself, does not parse frames and does not raise interrupts.

Top module: `rxring_tracker`

## Requirements
- R1: A register write with `cfg_sel` = 0 loads `cfg_wdata[27:0]` as ring base address bits [35:8]. Bits 31:28 are dropped. A write with `cfg_sel` = 2 loads `cfg_wdata[31:0]` as status buffer address bits [35:4].
- R2: A register write with `cfg_sel` = 1 sets the host write index. Only the low RING_LOG2 bits are kept, and the low 3 bits are forced to zero. If any of `cfg_wdata[2:0]` is nonzero, the sticky flag `wptr_err` is set. Only reset clears it.
- R3: `ring_blocked` is high exactly when the read index equals the write index modulo the ring size. While it is high, no new descriptor fetch is started.
- R4: A fetch request is started only when the ring is not blocked, no buffer is held and no status write-back is pending. `fetch_req_addr` equals the ring base address plus 4 times the read index. Request and address stay unchanged until `fetch_req_ready`.
- R5: On `fetch_rsp_valid`, bits 27:0 of the returned word become `buf_addr[35:8]`, and `buf_addr[7:0]` is zero. Bits 31:28 of the word are ignored. `buf_valid` then stays high until a fill is accepted.
- R6: `fill_done` while `buf_valid` is high advances the read index by one and wraps from the last entry to 0. `fill_done` while `buf_valid` is low has no effect.
- R7: Every accepted fill produces exactly one status write-back request, visible from the next cycle.
  - `stat_data[11:0]` holds the filled descriptor's index, and bits 31:12 are zero.
  - `stat_addr` is the status base shifted left by 4.
  - The request is held stable until `stat_ready`.
- R8: `fetch_req_valid` and `stat_valid` are never high in the same cycle.
- R9: After reset, no request or buffer is offered, `ring_blocked` is high and `wptr_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 ring base, 1 write index, 2 status base |
| cfg_wdata | input | 32 | Register write data |
| fetch_req_valid | output | 1 | Descriptor read request |
| fetch_req_ready | input | 1 | Descriptor read request accepted |
| fetch_req_addr | output | 36 | Byte address of the descriptor word |
| fetch_rsp_valid | input | 1 | Descriptor word returned |
| fetch_rsp_data | input | 32 | Descriptor word |
| buf_valid | output | 1 | A buffer is offered to the datapath |
| buf_addr | output | 36 | Byte address of the offered buffer |
| fill_done | input | 1 | Datapath has filled the offered buffer |
| stat_valid | output | 1 | Status write-back request |
| stat_ready | input | 1 | Status write-back accepted |
| stat_addr | output | 36 | Byte address of the status buffer |
| stat_data | output | 32 | Status word with the filled index |
| ring_blocked | output | 1 | No free buffer: read index equals write index |
| wptr_err | output | 1 | Sticky flag for a misaligned write-index write |

## Verification
The hardest case to reach is the read index wrapping past the last ring entry and then stopping exactly on the write index. This needs the host index to be published non-monotonically across the wrap. The stimulus first publishes up to index 200. It then writes a value whose significant bits are 0 and whose upper bits are set, so that 56 more buffers drain through the wrap onto a blocked ring. A misaligned write is also mixed in, and it must leave the ring stalled. The responder adds random delays on fetch acceptance, descriptor return, status acceptance and fill. It also sends fill pulses while no buffer is held, and these must change nothing.

// File: rtl/rxr_pkg.sv
// Shared types for the receive ring index tracker.
package rxr_pkg;

    localparam int ADDR_W = 36;
    localparam int WORD_W = 32;

    // Register select codes on the configuration write port
    typedef enum logic [1:0] {
        SEL_RING_BASE = 2'd0,
        SEL_WR_IDX    = 2'd1,
        SEL_STAT_BASE = 2'd2
    } cfg_sel_e;

    // Descriptor fetch sequencer states
    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_REQ  = 2'd1,
        F_WAIT = 2'd2,
        F_HOLD = 2'd3
    } fetch_st_e;

endpackage

// File: rtl/rxr_cfg_regs.sv
// Configuration registers: ring base, host write index, status base.
// The write index keeps RING_LOG2 bits rounded down to a step of eight.
// A misaligned write sets a sticky error flag.
// Assumes 3 < RING_LOG2 <= 12.
module rxr_cfg_regs
    import rxr_pkg::*;
#(
    parameter int RING_LOG2 = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [WORD_W-1:0]    cfg_wdata,
    output logic [27:0]          ring_base,
    output logic [WORD_W-1:0]    stat_base,
    output logic [RING_LOG2-1:0] wr_idx,
    output logic                 wptr_err
);

    // Register updates from the write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_base <= '0;
            stat_base <= '0;
            wr_idx    <= '0;
            wptr_err  <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_RING_BASE: ring_base <= cfg_wdata[27:0];
                SEL_STAT_BASE: stat_base <= cfg_wdata;
                SEL_WR_IDX: begin
                    wr_idx <= {cfg_wdata[RING_LOG2-1:3], 3'b000};
                    if (|cfg_wdata[2:0]) wptr_err <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    a_r2_err_on_misalign: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_WR_IDX && |cfg_wdata[2:0]) |=> wptr_err);

    a_r2_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wptr_err |=> wptr_err);

    a_r2_idx_step8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == SEL_WR_IDX) |=> (wr_idx[2:0] == 3'b000));

endmodule

// File: rtl/rxr_fetch_ctl.sv
// Read position owner and descriptor fetch sequencer.
// Sequence: fetch the descriptor at the read index, hold the buffer for
// the datapath, then advance on a fill.
// A fetch starts only with a free buffer and no pending status write-back.
module rxr_fetch_ctl
    import rxr_pkg::*;
#(
    parameter int RING_LOG2 = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [27:0]          ring_base,
    input  logic [RING_LOG2-1:0] wr_idx,
    input  logic                 stat_busy,
    output logic                 fetch_req_valid,
    input  logic                 fetch_req_ready,
    output logic [ADDR_W-1:0]    fetch_req_addr,
    input  logic                 fetch_rsp_valid,
    input  logic [WORD_W-1:0]    fetch_rsp_data,
    output logic                 buf_valid,
    output logic [ADDR_W-1:0]    buf_addr,
    input  logic                 fill_done,
    output logic                 ring_blocked,
    output logic                 fill_accept,
    output logic [RING_LOG2-1:0] fill_idx
);

    localparam int PAD_W = ADDR_W - RING_LOG2 - 2;

    fetch_st_e            state;
    logic [RING_LOG2-1:0] rd_idx;
    logic [27:0]          buf_hi;
    logic [3:0]           unused_desc_hi;

    // Ring occupancy and outputs decoded from state
    always_comb begin
        ring_blocked    = (rd_idx == wr_idx);
        fetch_req_valid = (state == F_REQ);
        buf_valid       = (state == F_HOLD);
        fill_accept     = (state == F_HOLD) && fill_done;
        fill_idx        = rd_idx;
        fetch_req_addr  = {ring_base, 8'h00} + {{PAD_W{1'b0}}, rd_idx, 2'b00};
        buf_addr        = {buf_hi, 8'h00};
        unused_desc_hi  = fetch_rsp_data[31:28];
    end

    // Fetch sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= F_IDLE;
        end else begin
            case (state)
                F_IDLE: if (!ring_blocked && !stat_busy) state <= F_REQ;
                F_REQ:  if (fetch_req_ready) state <= F_WAIT;
                F_WAIT: if (fetch_rsp_valid) state <= F_HOLD;
                F_HOLD: if (fill_done) state <= F_IDLE;
                default: state <= F_IDLE;
            endcase
        end
    end

    // Read index advance and buffer address capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_idx <= '0;
            buf_hi <= '0;
        end else begin
            if (fill_accept) rd_idx <= rd_idx + 1'b1;
            if (state == F_WAIT && fetch_rsp_valid) buf_hi <= fetch_rsp_data[27:0];
        end
    end

    a_r3_no_fetch_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_req_valid) |-> $past(!ring_blocked && !stat_busy));

    a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_valid && !fetch_req_ready) |=> (fetch_req_valid && $stable(fetch_req_addr)));

    a_r5_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_valid && !fill_done) |=> (buf_valid && $stable(buf_addr)));

    a_r6_ignored_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_done && !buf_valid) |=> $stable(rd_idx));

    a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
        fill_accept |=> (rd_idx == $past(rd_idx) + 1'b1));

endmodule

// File: rtl/rxr_status_wb.sv
// Status write-back holder. Captures the filled index and status base on
// each accepted fill. Presents one request, held until acknowledged.
// Assumes the fetch side never accepts a fill while a request is pending.
module rxr_status_wb
    import rxr_pkg::*;
#(
    parameter int RING_LOG2 = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WORD_W-1:0]    stat_base,
    input  logic                 fill_accept,
    input  logic [RING_LOG2-1:0] fill_idx,
    output logic                 stat_valid,
    input  logic                 stat_ready,
    output logic [ADDR_W-1:0]    stat_addr,
    output logic [WORD_W-1:0]    stat_data
);

    logic [RING_LOG2-1:0] idx_q;
    logic [WORD_W-1:0]    base_q;

    // Request formatting from captured values
    always_comb begin
        stat_data = {{(WORD_W - RING_LOG2){1'b0}}, idx_q};
        stat_addr = {base_q, 4'h0};
    end

    // Request capture and release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_valid <= 1'b0;
            idx_q      <= '0;
            base_q     <= '0;
        end else if (fill_accept) begin
            stat_valid <= 1'b1;
            idx_q      <= fill_idx;
            base_q     <= stat_base;
        end else if (stat_ready) begin
            stat_valid <= 1'b0;
        end
    end

    a_r7_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
        fill_accept |-> !stat_valid);

    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && !stat_ready) |=> (stat_valid && $stable(stat_data) && $stable(stat_addr)));

    a_r7_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
        fill_accept |=> stat_valid);

endmodule

// File: rtl/rxring_tracker.sv
// Receive descriptor ring index tracker, top level.
// Ties the configuration registers, the fetch sequencer and the status
// write-back holder together. Ring size is 2^RING_LOG2 entries.
module rxring_tracker
    import rxr_pkg::*;
#(
    parameter int RING_LOG2 = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic        fetch_req_valid,
    input  logic        fetch_req_ready,
    output logic [35:0] fetch_req_addr,
    input  logic        fetch_rsp_valid,
    input  logic [31:0] fetch_rsp_data,
    output logic        buf_valid,
    output logic [35:0] buf_addr,
    input  logic        fill_done,
    output logic        stat_valid,
    input  logic        stat_ready,
    output logic [35:0] stat_addr,
    output logic [31:0] stat_data,
    output logic        ring_blocked,
    output logic        wptr_err
);

    logic [27:0]          ring_base;
    logic [WORD_W-1:0]    stat_base;
    logic [RING_LOG2-1:0] wr_idx;
    logic                 fill_accept;
    logic [RING_LOG2-1:0] fill_idx;

    rxr_cfg_regs #(.RING_LOG2(RING_LOG2)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ring_base (ring_base),
        .stat_base (stat_base),
        .wr_idx    (wr_idx),
        .wptr_err  (wptr_err)
    );

    rxr_fetch_ctl #(.RING_LOG2(RING_LOG2)) u_fetch (
        .clk             (clk),
        .rst_n           (rst_n),
        .ring_base       (ring_base),
        .wr_idx          (wr_idx),
        .stat_busy       (stat_valid),
        .fetch_req_valid (fetch_req_valid),
        .fetch_req_ready (fetch_req_ready),
        .fetch_req_addr  (fetch_req_addr),
        .fetch_rsp_valid (fetch_rsp_valid),
        .fetch_rsp_data  (fetch_rsp_data),
        .buf_valid       (buf_valid),
        .buf_addr        (buf_addr),
        .fill_done       (fill_done),
        .ring_blocked    (ring_blocked),
        .fill_accept     (fill_accept),
        .fill_idx        (fill_idx)
    );

    rxr_status_wb #(.RING_LOG2(RING_LOG2)) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_base   (stat_base),
        .fill_accept (fill_accept),
        .fill_idx    (fill_idx),
        .stat_valid  (stat_valid),
        .stat_ready  (stat_ready),
        .stat_addr   (stat_addr),
        .stat_data   (stat_data)
    );

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_req_valid && stat_valid));

endmodule

// File: tb/test_rxring_tracker.sv
`timescale 1ns/100ps
module test_rxring_tracker;

    localparam int K = 8;
    localparam int N = 1 << K;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        fetch_req_valid;
    logic        fetch_req_ready = 1'b0;
    logic [35:0] fetch_req_addr;
    logic        fetch_rsp_valid = 1'b0;
    logic [31:0] fetch_rsp_data = 32'd0;
    logic        buf_valid;
    logic [35:0] buf_addr;
    logic        fill_done = 1'b0;
    logic        stat_valid;
    logic        stat_ready = 1'b0;
    logic [35:0] stat_addr;
    logic [31:0] stat_data;
    logic        ring_blocked;
    logic        wptr_err;

    rxring_tracker #(.RING_LOG2(K)) i_rxring_tracker (.*);

    always #2.5 clk = ~clk;

    // reference model state
    int          errors = 0;
    int          checks = 0;
    int          rd_m = 0;
    int          wr_m = 0;
    bit          err_m = 1'b0;
    longint      rb_m = 0;
    longint      sb_m = 0;
    int          stat_q[$];
    int          fills = 0;
    bit          run = 1'b0;
    bit          done = 1'b0;

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] desc_word(int idx);
        return {4'hC, 28'(idx * 7 + 3)};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // cycle-by-cycle model, checks and memory/datapath responder
    initial begin
        bit fill_sent = 0, stat_hs = 0, fetch_hs = 0, rsp_sent = 0;
        bit waiting = 0, holding = 0;
        int delay = 0, cur_idx = 0;
        forever begin
            @(negedge clk);
            if (!run) continue;
            // effects of the previous edge
            if (stat_hs) void'(stat_q.pop_front());
            if (fill_sent) begin
                stat_q.push_back(rd_m);
                rd_m = (rd_m + 1) % N;
                fills++;
                holding = 0;
            end
            if (fetch_hs) begin
                waiting = 1;
                cur_idx = rd_m;
                delay = $urandom_range(0, 3);
            end
            if (rsp_sent) holding = 1;
            fill_sent = 0; stat_hs = 0; fetch_hs = 0; rsp_sent = 0;
            fill_done = 0; fetch_req_ready = 0; fetch_rsp_valid = 0; stat_ready = 0;

            check("R3", "ring_blocked", longint'(ring_blocked), longint'(rd_m == wr_m));
            check("R2", "wptr_err", longint'(wptr_err), longint'(err_m));
            check("R7", "stat_valid vs pending fills", longint'(stat_valid), longint'(stat_q.size() != 0));
            check("R5", "buf_valid held", longint'(buf_valid), longint'(holding));

            if (fetch_req_valid) begin
                check("R4", "fetch_req_addr", longint'(fetch_req_addr), (rb_m << 8) + longint'(rd_m) * 4);
                check("R3", "fetch while blocked", longint'(rd_m == wr_m), 0);
                check("R8", "fetch with status pending", longint'(stat_valid), 0);
                if ($urandom_range(0, 2) == 0) begin
                    fetch_req_ready = 1;
                    fetch_hs = 1;
                end
            end
            if (waiting) begin
                if (delay == 0) begin
                    fetch_rsp_valid = 1;
                    fetch_rsp_data = desc_word(cur_idx);
                    waiting = 0;
                    rsp_sent = 1;
                end else begin
                    delay--;
                end
            end
            if (buf_valid) begin
                check("R5", "buf_addr", longint'(buf_addr), longint'(28'(cur_idx * 7 + 3)) << 8);
                if ($urandom_range(0, 2) == 0) begin
                    fill_done = 1;
                    fill_sent = 1;
                end
            end else if ($urandom_range(0, 5) == 0) begin
                fill_done = 1; // R6: must be ignored with no buffer held
            end
            if (stat_valid && stat_q.size() != 0) begin
                check("R7", "stat_data", longint'(stat_data), longint'(stat_q[0]));
                check("R7", "stat_addr", longint'(stat_addr), sb_m << 4);
                if ($urandom_range(0, 1) == 0) begin
                    stat_ready = 1;
                    stat_hs = 1;
                end
            end
        end
    end

    task automatic write_cfg(int sel, logic [31:0] data);
        @(negedge clk);
        cfg_we = 1; cfg_sel = 2'(sel); cfg_wdata = data;
        @(posedge clk);
        #1;
        cfg_we = 0;
        case (sel)
            0: rb_m = longint'(data[27:0]);
            1: begin
                wr_m = int'(data[K-1:0]) & ~7;
                if (data[2:0] != 0) err_m = 1;
            end
            2: sb_m = longint'(data);
            default: ;
        endcase
    endtask

    task automatic wait_rd(int target, string req);
        int n = 0;
        while (rd_m != target && n < 20000) begin
            @(posedge clk);
            n++;
        end
        check(req, "read index reached", rd_m, target);
    endtask

    // watchdog
    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R9", "reset fetch_req_valid", longint'(fetch_req_valid), 0);
        check("R9", "reset stat_valid", longint'(stat_valid), 0);
        check("R9", "reset buf_valid", longint'(buf_valid), 0);
        check("R9", "reset ring_blocked", longint'(ring_blocked), 1);
        check("R9", "reset wptr_err", longint'(wptr_err), 0);
        rst_n = 1;
        run = 1;

        write_cfg(0, 32'hFF0A_BCDE);   // R1: top nibble dropped
        write_cfg(2, 32'h89AB_CDE1);   // R1: status base
        repeat (20) @(posedge clk);
        check("R3", "no fill on empty ring", fills, 0);

        write_cfg(1, 32'd8);
        wait_rd(8, "R6");
        repeat (10) @(posedge clk);
        check("R3", "stall at write index", fills, 8);

        write_cfg(1, 32'd13);          // R2: rounds to 8, sets error
        repeat (30) @(posedge clk);
        check("R2", "misaligned write no progress", fills, 8);

        write_cfg(1, 32'd200);
        wait_rd(200, "R4");

        write_cfg(2, 32'h0000_1230);   // status base change between fills
        write_cfg(1, 32'h0000_0F00);   // R2: significant bits are 0 -> wrap
        wait_rd(0, "R6");
        repeat (10) @(posedge clk);
        check("R6", "fills through wrap", fills, 256);

        write_cfg(1, 32'd248);
        wait_rd(248, "R3");
        repeat (20) @(posedge clk);
        check("R3", "max outstanding fills", fills, 256 + 248);
        check("R2", "error still sticky", longint'(wptr_err), 1);
        finish_run();
    end

endmodule